// File: doc/BRIEF.md
# Instruction-Cycle Timer with Prescaler

This block is an 8-bit up-counter for a small processor. The processor runs on a four-phase instruction clock: one instruction cycle lasts four periods of the fast clock, marked by the strobes Q1 to Q4. The counter can advance once per instruction cycle. It can also advance on edges of an external pin or of a comparator output, with a choice of rising or falling edge. In every case a power-of-two prescaler can divide the event rate first. External events are sampled onto the Q2 and Q4 strobes before they reach the counter, so the count only changes on those phases.

The processor loads and reads the count through a simple write-strobe and read-data pair. It sets the mode through a 6-bit control word. A load of the count clears the prescaler. It also stops the counter for the next two instruction cycles, so a read just after a load returns the loaded value three times before counting resumes. When an external source is chosen, an output tells the pin logic to treat the pin as an input.

Top module: `icyc_timer`

## Requirements
- R1: After reset the count reads 00h and the control word is 111111b (external source, falling edge, prescaler bypassed), so the pin-input-force output is 1. With the inputs held static, the count stays at 00h.
- R2: With control word 001000b (internal source, rising, bypass, rate 0), the count rises by exactly 1 at the Q4 strobe of each instruction cycle and does not change on other phases. It wraps from FFh to 00h.
- R3: A count write of N on a Q4 strobe makes the reads at Q2 of the next three instruction cycles return N. The two reads after those return N+1 and N+2.
- R4: When bit 3 of the control word is 0, bits 2:0 hold the rate p and the prescaler counts source events. The count advances when prescaler bit p goes from 0 to 1. After e events following a clear, the total advance is floor((e + 2^p) / 2^(p+1)), which gives a ratio of 1:2^(p+1). A count write clears the prescaler.
- R5: With bit 5 set (external source), bit 4 clear (rising) and bit 3 set (bypass), each rising edge of the pin adds 1. A falling edge adds nothing. The count changes only on Q2 or Q4 strobes.
- R6: With bit 4 set, the external source counts falling edges, and rising edges have no effect.
- R7: When cmp_src_sel is 1, the comparator input is the external source and pin edges are ignored.
- R8: The external source also goes through the prescaler. With rate 0 and no bypass, pin pulses 1 to 4 leave the count at +1, +1, +2, +2.
- R9: The pin-input-force output equals bit 5 of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (four periods per instruction cycle) |
| rst | input | 1 | Synchronous active-high reset |
| phase | input | 4 | One-hot phase strobe, bit 0 = Q1 … bit 3 = Q4 |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | 8 | Value to load into the count |
| cnt_rdata | output | 8 | Current count |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: [5] external, [4] falling, [3] bypass, [2:0] rate |
| cmp_src_sel | input | 1 | 1 selects comparator input as external source |
| ext_pin | input | 1 | External clock pin |
| cmp_in | input | 1 | Comparator output |
| pin_force_in | output | 1 | Forces the pin to act as an input |

## Verification
The internal source is tried with a plain load followed by free counting, which separates the three-read stall from an immediate or a longer stall. A load of FEh shows the wrap. Two prescale rates are tried, including a reload in the middle of a prescale period; the reload only gives the expected sequence if the prescaler is cleared. On the external side, pulse trains and single edges on the pin tell rising-edge counting from falling-edge counting. Pulses on the unselected input set apart the pin and comparator paths. Counting pulses one at a time through the prescaler confirms the first advance after one edge and every second edge after that.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W   = 8;
  localparam int RATE_W  = 3;
  localparam int CTRL_W  = RATE_W + 3;
  localparam int PSC_W   = 1 << RATE_W;
  localparam int HOLD_CY = 2;
  localparam int PH_Q2   = 1;
  localparam int PH_Q4   = 3;

  typedef struct packed {
    logic              src_ext;
    logic              edge_fall;
    logic              psc_bypass;
    logic [RATE_W-1:0] rate;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int RATE_W = 3,
  localparam int PSC_W = 1 << RATE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              freeze,
  input  logic              src_ext,
  input  logic              bypass,
  input  logic [RATE_W-1:0] rate,
  input  logic              q4_stb,
  input  logic              ext_lvl,
  output logic              int_tick,
  output logic              ext_out
);
  logic [PSC_W-1:0] psc, psc_nxt;
  logic             lvl_d;
  logic             ext_rise, src_ev, adv;

  assign ext_rise = ext_lvl & ~lvl_d;
  assign src_ev   = src_ext ? ext_rise : q4_stb;
  assign adv      = src_ev & ~freeze & ~bypass;
  assign psc_nxt  = psc + 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) psc <= '0;
    else if (adv)   psc <= psc_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_d <= 1'b0;
    else     lvl_d <= ext_lvl;
  end

  assign int_tick = ~src_ext & q4_stb & ~freeze &
                    (bypass | (psc_nxt[rate] & ~psc[rate]));
  assign ext_out  = bypass ? ext_lvl : psc[rate];
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic din,
  output logic tick
);
  logic s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (stb) begin
      s1 <= din;
      s2 <= s1;
    end
  end

  assign tick = stb & s1 & ~s2;
endmodule

// File: rtl/tmr_hold.sv
module tmr_hold #(
  parameter int HOLD_CY = 2,
  localparam int HW = $clog2(HOLD_CY + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic q4_stb,
  output logic active
);
  logic [HW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)                      left <= '0;
    else if (load)                left <= HW'(HOLD_CY);
    else if (q4_stb && left != 0) left <= left - 1'b1;
  end

  assign active = (left != 0);
endmodule

// File: rtl/icyc_timer.sv
module icyc_timer
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        phase,
  input  logic              cnt_we,
  input  logic [CNT_W-1:0]  cnt_wdata,
  output logic [CNT_W-1:0]  cnt_rdata,
  input  logic              ctl_we,
  input  logic [CTRL_W-1:0] ctl_wdata,
  input  logic              cmp_src_sel,
  input  logic              ext_pin,
  input  logic              cmp_in,
  output logic              pin_force_in
);
  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] count_q;
  logic             raw, raw_q;
  logic             q2, q4;
  logic             hold_active;
  logic             int_tick, ext_out, ext_tick, inc;
  logic             ctl_src_ext, ctl_bypass;

  assign q2 = phase[PH_Q2];
  assign q4 = phase[PH_Q4];

  always_ff @(posedge clk) begin
    if (rst)         ctrl_q <= '1;
    else if (ctl_we) ctrl_q <= tmr_ctrl_t'(ctl_wdata);
  end

  assign ctl_src_ext = ctrl_q.src_ext;
  assign ctl_bypass  = ctrl_q.psc_bypass;

  assign raw = (cmp_src_sel ? cmp_in : ext_pin) ^ ctrl_q.edge_fall;

  always_ff @(posedge clk) begin
    if (rst) raw_q <= 1'b0;
    else     raw_q <= raw;
  end

  tmr_hold #(.HOLD_CY(HOLD_CY)) u_hold (
    .clk    (clk),
    .rst    (rst),
    .load   (cnt_we),
    .q4_stb (q4),
    .active (hold_active)
  );

  tmr_prescaler #(.RATE_W(RATE_W)) u_psc (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_we),
    .freeze   (hold_active),
    .src_ext  (ctrl_q.src_ext),
    .bypass   (ctrl_q.psc_bypass),
    .rate     (ctrl_q.rate),
    .q4_stb   (q4),
    .ext_lvl  (raw_q),
    .int_tick (int_tick),
    .ext_out  (ext_out)
  );

  tmr_sync u_sync (
    .clk  (clk),
    .rst  (rst),
    .stb  (q2 | q4),
    .din  (ext_out),
    .tick (ext_tick)
  );

  assign inc = ~hold_active & (ctrl_q.src_ext ? ext_tick : int_tick);

  always_ff @(posedge clk) begin
    if (rst)         count_q <= '0;
    else if (cnt_we) count_q <= cnt_wdata;
    else if (inc)    count_q <= count_q + 1'b1;
  end

  assign cnt_rdata    = count_q;
  assign pin_force_in = ctrl_q.src_ext;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       phase,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] cnt_rdata,
  input logic             src_ext,
  input logic             bypass,
  input logic             hold_active
);
  assert_write_load_R3: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_rdata == $past(cnt_wdata));

  assert_hold_freeze_R3: assert property (@(posedge clk) disable iff (rst)
    (hold_active && !cnt_we) |=> $stable(cnt_rdata));

  assert_int_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!src_ext && bypass && phase[3] && !hold_active && !cnt_we)
      |=> cnt_rdata == CNT_W'($past(cnt_rdata) + 1'b1));

  assert_int_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (!src_ext && !phase[3] && !cnt_we) |=> $stable(cnt_rdata));

  assert_ext_phase_R5: assert property (@(posedge clk) disable iff (rst)
    (src_ext && !phase[1] && !phase[3] && !cnt_we) |=> $stable(cnt_rdata));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    !cnt_we |=> ($stable(cnt_rdata) ||
                 cnt_rdata == CNT_W'($past(cnt_rdata) + 1'b1)));
endmodule

bind icyc_timer tmr_checker #(.CNT_W(tmr_pkg::CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .phase       (phase),
  .cnt_we      (cnt_we),
  .cnt_wdata   (cnt_wdata),
  .cnt_rdata   (cnt_rdata),
  .src_ext     (ctl_src_ext),
  .bypass      (ctl_bypass),
  .hold_active (hold_active)
);

// File: tb/icyc_timer_test.sv
module icyc_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ph = 2'd0;
  logic [3:0] phase;
  logic       cnt_we = 1'b0;
  logic [7:0] cnt_wdata = 8'h00;
  logic [7:0] cnt_rdata;
  logic       ctl_we = 1'b0;
  logic [5:0] ctl_wdata = 6'h00;
  logic       cmp_src_sel = 1'b0;
  logic       ext_pin = 1'b1;
  logic       cmp_in = 1'b1;
  logic       pin_force_in;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  event       cmp_ev;

  always #5 clk = ~clk;
  always @(posedge clk) ph <= ph + 2'd1;
  assign phase = 4'b0001 << ph;

  icyc_timer uut (
    .clk(clk), .rst(rst), .phase(phase),
    .cnt_we(cnt_we), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmp_src_sel(cmp_src_sel), .ext_pin(ext_pin), .cmp_in(cmp_in),
    .pin_force_in(pin_force_in)
  );

  // scoreboard monitor
  initial forever begin
    @(cmp_ev);
    begin
      logic [7:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (cnt_rdata !== e) begin
        errors++;
        $display("FAIL %s count actual %02h expected %02h at %0t", t, cnt_rdata, e, $time);
      end
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic to_phase(logic [1:0] p);
    do @(negedge clk); while (ph != p);
  endtask

  task automatic load_q4(logic [7:0] v, logic with_ctl, logic [5:0] c);
    to_phase(2'd3);
    cnt_we = 1'b1; cnt_wdata = v;
    ctl_we = with_ctl; ctl_wdata = c;
    @(negedge clk);
    cnt_we = 1'b0; ctl_we = 1'b0;
  endtask

  task automatic expect_q2(logic [7:0] v, string r);
    exp_q.push_back(v);
    tag_q.push_back(r);
    to_phase(2'd1);
    -> cmp_ev;
    #1;
  endtask

  task automatic check_force(logic e, string r);
    checks++;
    if (pin_force_in !== e) begin
      errors++;
      $display("FAIL %s pin_force_in actual %0b expected %0b", r, pin_force_in, e);
    end
  endtask

  task automatic pin_pulse();
    ext_pin = 1'b1; wait_clk(8);
    ext_pin = 1'b0; wait_clk(8);
  endtask

  task automatic cmp_pulse();
    cmp_in = 1'b1; wait_clk(8);
    cmp_in = 1'b0; wait_clk(8);
  endtask

  function automatic logic [7:0] psc_adv(int e, int p);
    return 8'((e + (1 << p)) / (1 << (p + 1)));
  endfunction

  initial begin
    wait_clk(4);
    rst = 1'b0;
    // R1: reset state
    expect_q2(8'h00, "R1");
    check_force(1'b1, "R1");
    wait_clk(32);
    expect_q2(8'h00, "R1");

    // R2/R3: internal, no prescaler, load 40h
    load_q4(8'h40, 1'b1, 6'b001000);
    expect_q2(8'h40, "R3");
    expect_q2(8'h40, "R3");
    expect_q2(8'h40, "R3");
    expect_q2(8'h41, "R3");
    expect_q2(8'h42, "R3");
    expect_q2(8'h43, "R2");
    check_force(1'b0, "R9");
    ext_pin = 1'b0;

    // R2: wrap
    load_q4(8'hFE, 1'b0, 6'b0);
    expect_q2(8'hFE, "R2");
    expect_q2(8'hFE, "R2");
    expect_q2(8'hFE, "R2");
    expect_q2(8'hFF, "R2");
    expect_q2(8'h00, "R2");
    expect_q2(8'h01, "R2");

    // R4: prescaler rate 1 (1:4)
    load_q4(8'h00, 1'b1, 6'b000001);
    for (int k = 1; k <= 12; k++)
      expect_q2(psc_adv(k > 3 ? k - 3 : 0, 1), "R4");
    // R4: reload mid period clears prescaler
    load_q4(8'h10, 1'b0, 6'b0);
    for (int k = 1; k <= 12; k++)
      expect_q2(8'h10 + psc_adv(k > 3 ? k - 3 : 0, 1), "R4");
    // R4: rate 2 (1:8)
    load_q4(8'h80, 1'b1, 6'b000010);
    for (int k = 1; k <= 20; k++)
      expect_q2(8'h80 + psc_adv(k > 3 ? k - 3 : 0, 2), "R4");

    // R5: external pin, rising, bypass
    load_q4(8'h00, 1'b1, 6'b101000);
    wait_clk(12);
    check_force(1'b1, "R9");
    for (int i = 0; i < 3; i++) pin_pulse();
    wait_clk(4);
    expect_q2(8'h03, "R5");
    ext_pin = 1'b1; wait_clk(12);
    expect_q2(8'h04, "R5");
    ext_pin = 1'b0; wait_clk(12);
    expect_q2(8'h04, "R5");

    // R6: falling edge select
    load_q4(8'h00, 1'b1, 6'b111000);
    wait_clk(12);
    ext_pin = 1'b1; wait_clk(12);
    expect_q2(8'h00, "R6");
    ext_pin = 1'b0; wait_clk(12);
    expect_q2(8'h01, "R6");

    // R7: comparator source
    cmp_in = 1'b0;
    wait_clk(2);
    cmp_src_sel = 1'b1;
    load_q4(8'h00, 1'b1, 6'b101000);
    wait_clk(12);
    pin_pulse(); pin_pulse();
    expect_q2(8'h00, "R7");
    cmp_pulse(); cmp_pulse();
    wait_clk(4);
    expect_q2(8'h02, "R7");

    // R8: external through prescaler rate 0
    cmp_src_sel = 1'b0;
    load_q4(8'h00, 1'b1, 6'b100000);
    wait_clk(12);
    for (int i = 1; i <= 4; i++) begin
      pin_pulse();
      wait_clk(4);
      expect_q2(psc_adv(i, 0), "R8");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule